// File: doc/BRIEF.md
# Background PHY Status Poller with Host Handoff

The poller walks a set of attached PHYs in turn, reads one status word from each over a shared read bus, and keeps a decoded status word per port: link, speed, duplex and flow control. A single enable input asks it to run or to stop. A two-bit run-state output tells the host whether the poller really holds the bus, which can differ from what the enable asks for.

While the poller holds the bus, host PHY reads are stalled. Once it has let go, they pass straight through to the PHY bus. The handoff is safe in both directions. A stop request lets the read already in flight finish before the poller reports stopped. A start request waits a fixed number of cycles and for the host to release the bus before the poller takes it.

The PHY bus uses a held request with a one-cycle acknowledge. The raw PHY word is read in this layout: bit 0 link, bits 2:1 speed code, bit 3 full duplex, bit 4 pause.

Top module: `ppu_top`

## Requirements
- R1: After reset, run_state is 00, every port status word is zero and phy_req is low.
- R2: run_state is 00 when stopped, 01 while starting, and 11 while running or finishing a read; it never shows 10.
- R3: When poll_en is seen high in the stopped state, run_state is 01 for START_DLY cycles and then 11, provided host_req is low. While host_req is high the poller stays in 01. Dropping poll_en during startup gives 00 on the next cycle. The first read after run_state turns 11 is issued one cycle later, to port 0.
- R4: While run_state is not 11, phy_req and phy_port follow host_req and host_port, host_ack follows phy_ack, and host_rdata carries the PHY data.
- R5: When poll_en drops while running, a read in flight keeps phy_req high until its acknowledge. run_state stays 11 through that acknowledge cycle and is 00 on the next cycle, with phy_req low when the host is idle.
- R6: Ports are read in the order 0,1,…,NPORTS-1 and then wrap. A status word changes only in the cycle after a poller read is acknowledged, and at most one port changes per cycle.
- R7: While run_state is 11, host_ack stays low whatever host_req does.
- R8: For a port whose raw link bit is 1, the status word has bit 11 set, bits 9:8 equal to the raw speed code (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s), bit 10 equal to duplex and bit 15 equal to pause, with all other bits 0. When the link bit is 0 the whole word is 0.
- R9: The reserved speed code 11 is reported unchanged as 11 in bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Request to run (1) or stop (0) |
| run_state | output | 2 | 00 stopped, 01 starting, 11 running |
| host_req | input | 1 | Host PHY read request, held until acknowledged |
| host_port | input | PW | Port addressed by the host |
| host_ack | output | 1 | Host read acknowledge |
| host_rdata | output | 16 | Raw PHY data returned to the host |
| phy_req | output | 1 | PHY bus read request |
| phy_port | output | PW | Port addressed on the PHY bus |
| phy_ack | input | 1 | PHY bus one-cycle acknowledge |
| phy_rdata | input | 16 | Raw PHY status word, valid with phy_ack |
| port_status | output | 16*NPORTS | Decoded status words, port i at bits 16*i+15:16*i |

## Verification
The decode path is driven with random raw words under random PHY latencies, plus directed words: link down with the other fields set, the reserved speed code, and all fields set. This separates masking faults from field-placement faults. Stops are requested at random points, including in the middle of an acknowledge wait, to expose a poller that abandons a read or reports stopped too early. Host reads are tried in the stopped state, while running, and during startup, which shows whether ownership follows the reported state.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
  localparam int SW = 16;

  // internal controller states
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_START = 2'b01,
    ST_DRAIN = 2'b10,
    ST_RUN   = 2'b11
  } ppu_state_e;

  // raw PHY word field positions
  localparam int RAW_LINK  = 0;
  localparam int RAW_SPD_L = 1;
  localparam int RAW_DUP   = 3;
  localparam int RAW_PAUSE = 4;

  // decoded status word field positions
  localparam int ST_SPD_L  = 8;
  localparam int ST_DUP    = 10;
  localparam int ST_LINK   = 11;
  localparam int ST_FC     = 15;

  function automatic logic [SW-1:0] pack_status(input logic [SW-1:0] raw);
    logic [SW-1:0] s;
    s = '0;
    if (raw[RAW_LINK]) begin
      s[ST_LINK]            = 1'b1;
      s[ST_SPD_L+1 -: 2]    = raw[RAW_SPD_L+1 -: 2];
      s[ST_DUP]             = raw[RAW_DUP];
      s[ST_FC]              = raw[RAW_PAUSE];
    end
    return s;
  endfunction
endpackage

// File: rtl/ppu_ctrl.sv
module ppu_ctrl
  import ppu_pkg::*;
#(
  parameter int START_DLY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_en,
  input  logic       host_req,
  input  logic       scan_busy,
  input  logic       phy_ack,
  output ppu_state_e state,
  output logic [1:0] run_state
);
  localparam int CW = (START_DLY > 1) ? $clog2(START_DLY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(START_DLY - 1);

  ppu_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (poll_en) begin
          state_d = ST_START;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_START: begin
        if (!poll_en) begin
          state_d = ST_OFF;
        end else if (cnt_q == CNT_LAST) begin
          if (!host_req) state_d = ST_RUN;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (!poll_en) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        // leave only when no poller read remains outstanding
        if (!scan_busy || phy_ack) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state = state_q;

  always_comb begin
    case (state_q)
      ST_OFF:   run_state = 2'b00;
      ST_START: run_state = 2'b01;
      default:  run_state = 2'b11;
    endcase
  end
endmodule

// File: rtl/ppu_scan.sv
module ppu_scan #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          clear,
  input  logic          phy_ack,
  output logic          busy,
  output logic [PW-1:0] port,
  output logic          wr_en
);
  localparam logic [PW-1:0] LAST = PW'(NPORTS - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  assign wr_en = busy_q && phy_ack;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (clear) begin
      busy_d = 1'b0;
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (wr_en) begin
      ptr_d  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      ptr_en = 1'b1;
      busy_d = go;
    end else if (!busy_q) begin
      busy_d = go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign busy = busy_q;
  assign port = ptr_q;
endmodule

// File: rtl/ppu_stat_bank.sv
module ppu_stat_bank
  import ppu_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_idx,
  input  logic [SW-1:0]        raw,
  output logic [NPORTS*SW-1:0] status_flat
);
  logic [SW-1:0] decoded;
  assign decoded = pack_status(raw);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [SW-1:0] word_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= decoded;
    end
    assign status_flat[i*SW +: SW] = word_q;
  end
endmodule

// File: rtl/ppu_top.sv
module ppu_top
  import ppu_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int START_DLY = 8,
  localparam int PW       = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 poll_en,
  output logic [1:0]           run_state,
  input  logic                 host_req,
  input  logic [PW-1:0]        host_port,
  output logic                 host_ack,
  output logic [15:0]          host_rdata,
  output logic                 phy_req,
  output logic [PW-1:0]        phy_port,
  input  logic                 phy_ack,
  input  logic [15:0]          phy_rdata,
  output logic [NPORTS*16-1:0] port_status
);
  ppu_state_e    state;
  logic          scan_busy, scan_wr, scan_go, scan_clear, own_bus;
  logic [PW-1:0] scan_port;

  ppu_ctrl #(.START_DLY(START_DLY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .host_req(host_req),
    .scan_busy(scan_busy), .phy_ack(phy_ack),
    .state(state), .run_state(run_state)
  );

  assign own_bus    = (state == ST_RUN) || (state == ST_DRAIN);
  assign scan_go    = (state == ST_RUN) && poll_en;
  assign scan_clear = !own_bus;

  ppu_scan #(.NPORTS(NPORTS), .PW(PW)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(scan_go), .clear(scan_clear),
    .phy_ack(phy_ack), .busy(scan_busy), .port(scan_port), .wr_en(scan_wr)
  );

  ppu_stat_bank #(.NPORTS(NPORTS), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(scan_wr), .wr_idx(scan_port),
    .raw(phy_rdata), .status_flat(port_status)
  );

  // bus ownership
  assign phy_req    = own_bus ? scan_busy : host_req;
  assign phy_port   = own_bus ? scan_port : host_port;
  assign host_ack   = own_bus ? 1'b0      : phy_ack;
  assign host_rdata = phy_rdata;
endmodule

// File: rtl/ppu_top_chk.sv
module ppu_top_chk #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           run_state,
  input logic                 host_req,
  input logic                 host_ack,
  input logic                 phy_req,
  input logic                 phy_ack,
  input logic [NPORTS*16-1:0] port_status
);
  p_no_code10_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_state != 2'b10);

  p_start_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_state == 2'b11) |-> $past(run_state) == 2'b01);

  p_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'b00 && !host_req) |-> !phy_req);

  p_hold_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'b11 && phy_req && !phy_ack) |=> (phy_req && run_state == 2'b11));

  p_update_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_status) |-> ($past(phy_ack) && $past(run_state) == 2'b11));

  p_host_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'b11 |-> !host_ack);
endmodule

bind ppu_top ppu_top_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_state(run_state), .host_req(host_req),
  .host_ack(host_ack), .phy_req(phy_req), .phy_ack(phy_ack),
  .port_status(port_status)
);

// File: tb/sim_ppu_top.sv
`timescale 1ns/1ps
module sim_ppu_top;
  localparam int NP  = 4;
  localparam int PW  = 2;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             poll_en = 1'b0;
  logic             host_req = 1'b0;
  logic [PW-1:0]    host_port = '0;
  logic [1:0]       run_state;
  logic             host_ack;
  logic [15:0]      host_rdata;
  logic             phy_req;
  logic [PW-1:0]    phy_port;
  logic             phy_ack;
  logic [15:0]      phy_rdata;
  logic [NP*16-1:0] port_status;

  logic [15:0] words [NP];
  int lat = 1;
  int checks = 0, errors = 0;

  ppu_top #(.NPORTS(NP), .START_DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .run_state(run_state),
    .host_req(host_req), .host_port(host_port), .host_ack(host_ack),
    .host_rdata(host_rdata), .phy_req(phy_req), .phy_port(phy_port),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .port_status(port_status)
  );

  function automatic logic [15:0] exp_status(input logic [15:0] w);
    if (!w[0]) return 16'h0000;
    return {w[4], 3'b000, 1'b1, w[3], w[2:1], 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // PHY responder model
  int wcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_ack <= 1'b0; phy_rdata <= '0; wcnt <= 0;
    end else if (phy_ack) begin
      phy_ack <= 1'b0; wcnt <= 0;
    end else if (phy_req) begin
      if (wcnt >= lat) begin
        phy_ack <= 1'b1; phy_rdata <= words[phy_port]; wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
  end

  // monitors, sampled mid-cycle
  int aborts = 0, rr_err = 0, rr_cnt = 0, code10 = 0, atom_err = 0, exp_next = 0;
  bit pend = 0, prev_ack = 0;
  logic [1:0] prev_run = 2'b00;
  logic [NP*16-1:0] prev_stat = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      int nchg;
      if (pend && !phy_req) aborts++;
      pend = phy_req && !phy_ack && run_state == 2'b11;
      if (run_state == 2'b10) code10++;
      if (run_state == 2'b01) exp_next = 0;
      if (phy_ack && run_state == 2'b11) begin
        rr_cnt++;
        if (int'(phy_port) != exp_next) rr_err++;
        exp_next = (int'(phy_port) + 1) % NP;
      end
      nchg = 0;
      for (int p = 0; p < NP; p++)
        if (port_status[p*16 +: 16] != prev_stat[p*16 +: 16]) nchg++;
      if (nchg > 1) atom_err++;
      if (nchg > 0 && !(prev_ack && prev_run == 2'b11)) atom_err++;
      prev_stat = port_status; prev_ack = phy_ack; prev_run = run_state;
    end
  end

  task automatic host_read(input int p, output logic [15:0] d, output bit got);
    got = 0; d = '0;
    @(negedge clk);
    host_req = 1'b1; host_port = PW'(p);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (host_ack) begin got = 1; d = host_rdata; break; end
    end
    host_req = 1'b0;
  endtask

  task automatic rand_words();
    for (int p = 0; p < NP; p++) words[p] = 16'($urandom);
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < NP; p++)
      chk(port_status[p*16 +: 16] == exp_status(words[p]), tag,
          port_status[p*16 +: 16], exp_status(words[p]));
  endtask

  task automatic start_run();
    @(negedge clk); poll_en = 1'b1;
    for (int i = 0; i < DLY + 1; i++) @(negedge clk);
  endtask

  // stop during a pending read and follow the drain (R5)
  task automatic stop_and_drain(input bit wait_pending);
    bit done = 0;
    if (wait_pending)
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (phy_req && !phy_ack && run_state == 2'b11) break;
      end
    poll_en = 1'b0;
    for (int i = 0; i < 60 && !done; i++) begin
      @(negedge clk);
      if (phy_ack) begin
        chk(run_state == 2'b11, "R5 state in ack cycle", run_state, 2'b11);
        @(negedge clk);
        chk(run_state == 2'b00, "R5 stopped after ack", run_state, 2'b00);
        chk(!phy_req, "R5 bus idle after stop", phy_req, 0);
        done = 1;
      end else if (run_state == 2'b00) begin
        chk(!phy_req, "R5 idle stop", phy_req, 0);
        done = 1;
      end else begin
        chk(run_state == 2'b11, "R5 held while draining", run_state, 2'b11);
      end
    end
    chk(done, "R5 drain finished", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    bit got;
    int acks;
    void'($urandom(32'd24681));
    rand_words();
    repeat (3) @(negedge clk);
    chk(run_state == 2'b00, "R1 run_state", run_state, 0);
    chk(port_status == '0, "R1 port_status", port_status[31:0], 0);
    chk(!phy_req, "R1 phy_req", phy_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 pass-through while stopped
    for (int p = 0; p < NP; p++) begin
      host_read(p, d, got);
      chk(got && d == words[p], "R4 host read stopped", d, words[p]);
    end

    // R3 startup timing and first port
    lat = 2;
    @(negedge clk); poll_en = 1'b1;
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);
      if (i == 1 || i == DLY) chk(run_state == 2'b01, "R3 starting", run_state, 2'b01);
    end
    @(negedge clk);
    chk(run_state == 2'b11, "R3 running after delay", run_state, 2'b11);
    @(negedge clk);
    chk(phy_req && phy_port == 0, "R3 first read port 0", {phy_req, phy_port}, {1'b1, 2'd0});

    // R8 decode under random words and latencies
    for (int r = 0; r < 8; r++) begin
      rand_words();
      if (r == 1) words[2] = 16'hFFFE;          // link down, other fields set
      if (r == 2) words[1] = 16'h001F;          // all fields set
      lat = int'($urandom % 4);
      repeat (90) @(negedge clk);
      check_all("R8 decoded word");
    end

    // R9 reserved speed code
    words[3] = 16'h0007;
    repeat (90) @(negedge clk);
    chk(port_status[3*16+8 +: 2] == 2'b11, "R9 reserved speed", port_status[3*16+8 +: 2], 2'b11);
    chk(port_status[3*16 +: 16] == 16'h0B00, "R9 reserved word", port_status[3*16 +: 16], 16'h0B00);

    // R7 host stalled while running
    acks = 0;
    @(negedge clk); host_req = 1'b1; host_port = 2'd1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (host_ack) acks++;
    end
    host_req = 1'b0;
    chk(acks == 0, "R7 host ack while running", acks, 0);

    // R5 stop in the middle of a read
    lat = 3;
    stop_and_drain(1'b1);
    host_read(2, d, got);
    chk(got && d == words[2], "R4 host read after stop", d, words[2]);

    // R3 enable dropped during startup
    @(negedge clk); poll_en = 1'b1;
    repeat (3) @(negedge clk);
    poll_en = 1'b0;
    @(negedge clk);
    chk(run_state == 2'b00, "R3 startup cancelled", run_state, 0);

    // R3 startup waits for host to release the bus
    @(negedge clk); host_req = 1'b1; host_port = 2'd0; poll_en = 1'b1;
    repeat (DLY + 4) @(negedge clk);
    chk(run_state == 2'b01, "R3 waits for host", run_state, 2'b01);
    host_req = 1'b0;
    @(negedge clk);
    chk(run_state == 2'b11, "R3 runs after host release", run_state, 2'b11);

    // random stop points
    for (int r = 0; r < 6; r++) begin
      lat = int'($urandom % 4);
      repeat (int'($urandom % 40) + 2) @(negedge clk);
      stop_and_drain(1'b0);
      start_run();
    end
    poll_en = 1'b0;
    repeat (20) @(negedge clk);

    chk(rr_cnt > 20 && rr_err == 0, "R6 round-robin order", rr_err, 0);
    chk(atom_err == 0, "R6 single-port update on ack", atom_err, 0);
    chk(aborts == 0, "R5 no abandoned read", aborts, 0);
    chk(code10 == 0, "R2 code 10 never shown", code10, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule